// File: doc/BRIEF.md
# Multibit Trie Route Lookup Engine

This block resolves a destination address to a next-hop adjacency index by longest-prefix match. The route table lives in an on-chip slot memory organised as a multibit trie of fixed per-level strides. Each level takes the next group of address bits, starting at the most significant end, and uses them as a direct index into the current node. The slot found there ends the walk with a leaf, ends it with a miss, or gives the base of a child node one level down. The slot contents are pre-expanded. A prefix shorter than a level boundary is copied into every slot it covers. Every slot not taken by a more specific route carries the leaf of the best shorter route, including a default route. The walk can therefore stop at the first leaf it meets and never compares prefixes.

A lookup is offered on a valid/ready request channel, and only one lookup is in flight at a time. The block reads one slot per clock, one per level. It then presents a response: a hit flag, the adjacency index, and the number of levels read. The response is held until the consumer takes it. A control-plane agent fills the memory through a write port with its own ready signal. Writes are accepted only between lookups, so a walk never sees a node in the middle of an update. The stride of each level, the number of levels, the memory depth and the field widths are parameters. The default is four levels of 8 bits over a 32-bit address.

Top module: `trie_lookup`

## Requirements
- R1: After reset, reqReady and wrReady are 1 and rspValid is 0.
- R2: The walk reads the root node's slots from memory address 0. Level l indexes its slot with the next STRIDE[l] address bits, taken from the most significant end. A child entry's payload is the base address of its node, and the slot read is base plus slot index. rspDepth equals the number of slots read.
- R3: A slot entry is a 2-bit kind above a payload. Kind 0 is empty, kind 1 is child, kind 2 is leaf, and kind 3 is treated as empty.
- R4: Reading a leaf ends the walk with rspHit=1 and rspAdj equal to the low ADJ_W bits of the leaf payload.
- R5: Reading an empty slot ends the walk with rspHit=0 and rspAdj=0.
- R6: A child entry read at the last level ends the walk as a miss with rspDepth equal to NUM_LEVELS.
- R7: rspValid rises exactly rspDepth clock cycles after the edge that accepts the request.
- R8: A response stays valid, with unchanged fields, until rspReady is seen. reqReady is 0 from acceptance until the response is taken.
- R9: wrReady is 0 while a lookup is being walked or its response is pending. Writes are held off until the block is idle, and a walk returns the table content from before the held write. When idle, a write takes priority and reqReady is 0 in any cycle in which wrEn is 1.
- R10: With a table filled by prefix expansion, every address returns the adjacency of its longest matching prefix, or a miss if no prefix matches. This holds for any per-level stride split, including a non-uniform one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request offered |
| reqReady | output | 1 | Lookup request can be accepted |
| reqAddr | input | ADDR_W | Destination address to resolve |
| rspValid | output | 1 | Lookup result available |
| rspReady | input | 1 | Consumer takes the result |
| rspHit | output | 1 | 1 when a leaf was found |
| rspAdj | output | ADJ_W | Adjacency index, 0 on a miss |
| rspDepth | output | LVL_W | Levels read by the walk |
| wrEn | input | 1 | Slot write offered |
| wrReady | output | 1 | Slot write is accepted this cycle |
| wrAddr | input | MEM_AW | Slot memory address |
| wrKind | input | 2 | Slot kind (0 empty, 1 child, 2 leaf) |
| wrData | input | PTR_W | Child base address or adjacency index |

## Verification
Some internal faults show at the ports within one lookup. A wrong level counter or a wrong slot field selects the wrong slot. That gives a wrong adjacency or a wrong depth for the addresses below the affected node, and the response latency stops matching the reported depth on the same response. A fault in the hand-off between the controller and the datapath shows up differently. The response can drop early, change while it is held, or appear while writes are still open. These faults are visible the cycle they happen. Sweeping every address of a small non-uniform configuration reaches every slot in the table, so a corrupted slot cannot hide behind addresses that were never tried.

// File: rtl/trie_pkg.sv
package trie_pkg;

  // Slot kind field stored above the payload of every memory entry
  typedef enum logic [1:0] {
    KIND_EMPTY = 2'd0,
    KIND_CHILD = 2'd1,
    KIND_LEAF  = 2'd2,
    KIND_RSVD  = 2'd3
  } slotKind_e;

  // Strobes from the walk controller to the datapath
  typedef struct packed {
    logic firstRead;   // latch address, read root slot
    logic nextRead;    // descend one level
    logic finishHit;   // capture leaf result
    logic finishMiss;  // capture miss result
    logic writeMem;    // commit load-port write
  } walkCtl_t;

endpackage

// File: rtl/trie_dpath.sv
module trie_dpath
  import trie_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_LEVELS = 4,
  parameter int unsigned STRIDE [NUM_LEVELS] = '{8, 8, 8, 8},
  parameter int MEM_DEPTH  = 2048,
  parameter int PTR_W      = 16,
  parameter int ADJ_W      = 12,
  parameter int MEM_AW     = $clog2(MEM_DEPTH),
  parameter int LVL_W      = $clog2(NUM_LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  walkCtl_t          ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [MEM_AW-1:0] wrAddr,
  input  logic [1:0]        wrKind,
  input  logic [PTR_W-1:0]  wrData,
  output slotKind_e         curKind,
  output logic              atLast,
  output logic              rspHit,
  output logic [ADJ_W-1:0]  rspAdj,
  output logic [LVL_W-1:0]  rspDepth
);

  function automatic int maxStride();
    int m = 1;
    for (int i = 0; i < NUM_LEVELS; i++) if (int'(STRIDE[i]) > m) m = int'(STRIDE[i]);
    return m;
  endfunction

  function automatic int bitsThrough(int lvl);
    int s = 0;
    for (int i = 0; i <= lvl; i++) s += int'(STRIDE[i]);
    return s;
  endfunction

  localparam int SLOT_W  = maxStride();
  localparam int ENTRY_W = PTR_W + 2;
  localparam int SH0     = ADDR_W - int'(STRIDE[0]);

  logic [ENTRY_W-1:0] mem [MEM_DEPTH];
  logic [ENTRY_W-1:0] rdQ;
  logic [ADDR_W-1:0]  addrQ;
  logic [LVL_W-1:0]   levelQ;
  logic [SLOT_W-1:0]  slotArr [NUM_LEVELS];
  logic [SLOT_W-1:0]  slotReq0;
  logic [SLOT_W-1:0]  nextSlot;
  logic [PTR_W-1:0]   payload;
  logic [MEM_AW-1:0]  rdAddr;

  // Per-level slot index fields of the latched address
  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_slot
    localparam int SH = ADDR_W - bitsThrough(l);
    localparam int SW = int'(STRIDE[l]);
    logic [ADDR_W-1:0] shifted;
    assign shifted    = addrQ >> SH;
    assign slotArr[l] = SLOT_W'(shifted & ADDR_W'((64'd1 << SW) - 64'd1));
  end

  assign slotReq0 = SLOT_W'(reqAddr >> SH0);
  assign payload  = rdQ[PTR_W-1:0];
  assign curKind  = slotKind_e'(rdQ[ENTRY_W-1 -: 2]);
  assign atLast   = (levelQ == LVL_W'(NUM_LEVELS - 1));

  always_comb begin
    nextSlot = '0;
    for (int l = 1; l < NUM_LEVELS; l++)
      if (levelQ == LVL_W'(l - 1)) nextSlot = slotArr[l];
  end

  always_comb begin
    if (ctl.firstRead) rdAddr = MEM_AW'(slotReq0);
    else               rdAddr = MEM_AW'(payload) + MEM_AW'(nextSlot);
  end

  // Slot memory: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (ctl.writeMem) mem[wrAddr] <= {wrKind, wrData};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           rdQ <= '0;
    else if (ctl.firstRead || ctl.nextRead) rdQ <= mem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrQ  <= '0;
      levelQ <= '0;
    end else if (ctl.firstRead) begin
      addrQ  <= reqAddr;
      levelQ <= '0;
    end else if (ctl.nextRead) begin
      levelQ <= levelQ + LVL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspHit   <= 1'b0;
      rspAdj   <= '0;
      rspDepth <= '0;
    end else if (ctl.finishHit) begin
      rspHit   <= 1'b1;
      rspAdj   <= ADJ_W'(payload);
      rspDepth <= levelQ + LVL_W'(1);
    end else if (ctl.finishMiss) begin
      rspHit   <= 1'b0;
      rspAdj   <= '0;
      rspDepth <= levelQ + LVL_W'(1);
    end
  end

endmodule

// File: rtl/trie_ctrl.sv
module trie_ctrl
  import trie_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reqValid,
  input  logic      wrEn,
  input  logic      rspReady,
  input  slotKind_e curKind,
  input  logic      atLast,
  output walkCtl_t  ctl,
  output logic      reqReady,
  output logic      wrReady,
  output logic      rspValid
);

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_RESP} walkState_e;

  walkState_e stQ, stNxt;

  always_comb begin
    ctl      = '0;
    stNxt    = stQ;
    reqReady = 1'b0;
    wrReady  = 1'b0;
    rspValid = 1'b0;
    unique case (stQ)
      ST_IDLE: begin
        wrReady      = 1'b1;
        reqReady     = !wrEn;
        ctl.writeMem = wrEn;
        if (reqValid && !wrEn) begin
          ctl.firstRead = 1'b1;
          stNxt         = ST_WALK;
        end
      end
      ST_WALK: begin
        if (curKind == KIND_LEAF) begin
          ctl.finishHit = 1'b1;
          stNxt         = ST_RESP;
        end else if (curKind == KIND_CHILD && !atLast) begin
          ctl.nextRead = 1'b1;
        end else begin
          ctl.finishMiss = 1'b1;
          stNxt          = ST_RESP;
        end
      end
      ST_RESP: begin
        rspValid = 1'b1;
        if (rspReady) stNxt = ST_IDLE;
      end
      default: stNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stQ <= ST_IDLE;
    else        stQ <= stNxt;
  end

endmodule

// File: rtl/trie_lookup.sv
module trie_lookup
  import trie_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_LEVELS = 4,
  parameter int unsigned STRIDE [NUM_LEVELS] = '{8, 8, 8, 8},
  parameter int MEM_DEPTH  = 2048,
  parameter int PTR_W      = 16,
  parameter int ADJ_W      = 12,
  localparam int MEM_AW    = $clog2(MEM_DEPTH),
  localparam int LVL_W     = $clog2(NUM_LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  input  logic              rspReady,
  output logic              rspHit,
  output logic [ADJ_W-1:0]  rspAdj,
  output logic [LVL_W-1:0]  rspDepth,
  input  logic              wrEn,
  output logic              wrReady,
  input  logic [MEM_AW-1:0] wrAddr,
  input  logic [1:0]        wrKind,
  input  logic [PTR_W-1:0]  wrData
);

  walkCtl_t  ctl;
  slotKind_e curKind;
  logic      atLast;

  trie_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .wrEn     (wrEn),
    .rspReady (rspReady),
    .curKind  (curKind),
    .atLast   (atLast),
    .ctl      (ctl),
    .reqReady (reqReady),
    .wrReady  (wrReady),
    .rspValid (rspValid)
  );

  trie_dpath #(
    .ADDR_W     (ADDR_W),
    .NUM_LEVELS (NUM_LEVELS),
    .STRIDE     (STRIDE),
    .MEM_DEPTH  (MEM_DEPTH),
    .PTR_W      (PTR_W),
    .ADJ_W      (ADJ_W),
    .MEM_AW     (MEM_AW),
    .LVL_W      (LVL_W)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .wrAddr   (wrAddr),
    .wrKind   (wrKind),
    .wrData   (wrData),
    .curKind  (curKind),
    .atLast   (atLast),
    .rspHit   (rspHit),
    .rspAdj   (rspAdj),
    .rspDepth (rspDepth)
  );

endmodule

// File: rtl/trie_lookup_chk.sv
module trie_lookup_chk #(
  parameter int NUM_LEVELS = 4,
  parameter int ADJ_W      = 12,
  parameter int LVL_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reqValid,
  input logic             reqReady,
  input logic             wrEn,
  input logic             wrReady,
  input logic             rspValid,
  input logic             rspReady,
  input logic             rspHit,
  input logic [ADJ_W-1:0] rspAdj,
  input logic [LVL_W-1:0] rspDepth
);

  logic       busy;
  logic [7:0] cyc;

  // Tracks an accepted lookup and the cycles spent before its response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cyc  <= '0;
    end else if (reqValid && reqReady) begin
      busy <= 1'b1;
      cyc  <= '0;
    end else begin
      if (rspValid && rspReady) busy <= 1'b0;
      if (busy && !rspValid)    cyc  <= cyc + 8'd1;
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid && !rspReady |=> rspValid && $stable(rspHit) && $stable(rspAdj) && $stable(rspDepth)); // R8
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !reqReady); // R8
  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wrReady); // R9
  AST_WR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && wrReady |-> !reqReady); // R9
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid && !rspHit |-> rspAdj == '0); // R5
  AST_DEPTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> (rspDepth >= LVL_W'(1)) && (rspDepth <= LVL_W'(NUM_LEVELS))); // R2
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rspValid) |-> rspDepth == LVL_W'(cyc)); // R7

endmodule

bind trie_lookup trie_lookup_chk #(
  .NUM_LEVELS (NUM_LEVELS),
  .ADJ_W      (ADJ_W),
  .LVL_W      (LVL_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .wrEn     (wrEn),
  .wrReady  (wrReady),
  .rspValid (rspValid),
  .rspReady (rspReady),
  .rspHit   (rspHit),
  .rspAdj   (rspAdj),
  .rspDepth (rspDepth)
);

// File: tb/trie_lookup_bench.sv
module trie_lookup_bench;

  localparam int ADDR_W = 8;
  localparam int NL     = 3;
  localparam int unsigned TB_STRIDE [NL] = '{3, 3, 2};
  localparam int DEPTH  = 64;
  localparam int PW     = 8;
  localparam int AW     = 4;
  localparam int MAW    = 6;
  localparam int LW     = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reqValid = 1'b0;
  logic           reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic           rspValid;
  logic           rspReady = 1'b0;
  logic           rspHit;
  logic [AW-1:0]  rspAdj;
  logic [LW-1:0]  rspDepth;
  logic           wrEn = 1'b0;
  logic           wrReady;
  logic [MAW-1:0] wrAddr = '0;
  logic [1:0]     wrKind = '0;
  logic [PW-1:0]  wrData = '0;

  always #4 clk = ~clk;

  trie_lookup #(
    .ADDR_W (ADDR_W), .NUM_LEVELS (NL), .STRIDE (TB_STRIDE),
    .MEM_DEPTH (DEPTH), .PTR_W (PW), .ADJ_W (AW)
  ) u_trie_lookup (
    .clk (clk), .rst_n (rst_n),
    .reqValid (reqValid), .reqReady (reqReady), .reqAddr (reqAddr),
    .rspValid (rspValid), .rspReady (rspReady), .rspHit (rspHit),
    .rspAdj (rspAdj), .rspDepth (rspDepth),
    .wrEn (wrEn), .wrReady (wrReady), .wrAddr (wrAddr),
    .wrKind (wrKind), .wrData (wrData)
  );

  int nChk = 0;
  int nBad = 0;
  int cycles = 0;
  bit doneFlag = 0;
  int rVal [6];
  int rLen [6];
  int rAdj [6];
  int nR = 0;
  int leafBase = 0;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model: address helpers over the route list
  function automatic bit topEq(int a, int b, int len);
    if (len == 0) return 1'b1;
    return ((a ^ b) >> (8 - len)) == 0;
  endfunction

  function automatic int bestCover(int p, int len);
    int bl = -1;
    int res = -1;
    for (int i = 0; i < nR; i++)
      if (rLen[i] <= len && rLen[i] > bl && topEq(p, rVal[i], rLen[i])) begin
        bl = rLen[i];
        res = rAdj[i];
      end
    return res;
  endfunction

  function automatic bit needChild(int p, int len);
    for (int i = 0; i < nR; i++)
      if (rLen[i] > len && topEq(p, rVal[i], len)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int expDepth(int a);
    if (!needChild(a, 3)) return 1;
    if (!needChild(a, 6)) return 2;
    return 3;
  endfunction

  task automatic wrEntry(input int a, input int kind, input int data);
    wrEn = 1'b1;
    wrAddr = MAW'(a);
    wrKind = 2'(kind);
    wrData = PW'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic writeBest(input int a, input int p, input int len);
    int b;
    b = bestCover(p, len);
    if (b < 0) wrEntry(a, 0, 0);
    else       wrEntry(a, 2, b);
  endtask

  // Prefix expansion of the route list into a 3-3-2 trie
  task automatic fillTable();
    int freeP;
    int b1;
    int b2;
    int p0;
    int p1;
    freeP = 8;
    for (int s0 = 0; s0 < 8; s0++) begin
      p0 = s0 << 5;
      if (needChild(p0, 3)) begin
        b1 = freeP;
        freeP += 8;
        wrEntry(s0, 1, b1);
        for (int s1 = 0; s1 < 8; s1++) begin
          p1 = p0 | (s1 << 2);
          if (needChild(p1, 6)) begin
            b2 = freeP;
            freeP += 4;
            leafBase = b2;
            wrEntry(b1 + s1, 1, b2);
            for (int s2 = 0; s2 < 4; s2++) writeBest(b2 + s2, p1 | s2, 8);
          end else begin
            writeBest(b1 + s1, p1, 6);
          end
        end
      end else begin
        writeBest(s0, p0, 3);
      end
    end
  endtask

  task automatic lookup(input int a, output int oHit, output int oAdj,
                        output int oDepth, output int oCyc);
    reqValid = 1'b1;
    reqAddr = ADDR_W'(a);
    @(negedge clk);
    reqValid = 1'b0;
    oCyc = 0;
    while (!rspValid && oCyc < 20) begin
      @(negedge clk);
      oCyc++;
    end
    oHit = int'(rspHit);
    oAdj = int'(rspAdj);
    oDepth = int'(rspDepth);
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
  endtask

  task automatic sweep();
    int h;
    int ad;
    int d;
    int c;
    int e;
    for (int a = 0; a < 256; a++) begin
      lookup(a, h, ad, d, c);
      e = bestCover(a, 8);
      chk((h != 0 ? ad : -1) == e, "R4 R5 R10 result", h != 0 ? ad : -1, e);
      if (h == 0) chk(ad == 0, "R5 adj zero on miss", ad, 0);
      chk(d == expDepth(a), "R2 depth", d, expDepth(a));
      chk(c == d, "R7 latency", c, d);
    end
  endtask

  initial begin
    int h;
    int ad;
    int d;
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 reqReady", int'(reqReady), 1);
    chk(wrReady == 1'b1, "R1 wrReady", int'(wrReady), 1);
    chk(rspValid == 1'b0, "R1 rspValid", int'(rspValid), 0);

    // Phase 1: no default route, so misses appear
    rVal[0] = 8'h40; rLen[0] = 2; rAdj[0] = 2;
    rVal[1] = 8'h60; rLen[1] = 5; rAdj[1] = 3;
    rVal[2] = 8'h64; rLen[2] = 8; rAdj[2] = 4;
    rVal[3] = 8'hA0; rLen[3] = 4; rAdj[3] = 5;
    nR = 4;
    fillTable();
    sweep();

    // Phase 2: default route fills every uncovered slot
    rVal[4] = 0; rLen[4] = 0; rAdj[4] = 1;
    nR = 5;
    fillTable();
    sweep();

    // R9: write held off during a walk, walk sees old content
    reqValid = 1'b1;
    reqAddr = 8'hF0;
    @(negedge clk);
    reqValid = 1'b0;
    wrEn = 1'b1; wrAddr = 6'd7; wrKind = 2'd2; wrData = 8'd9;
    chk(wrReady == 1'b0, "R9 wrReady low during walk", int'(wrReady), 0);
    c = 0;
    while (!rspValid && c < 20) begin
      @(negedge clk);
      c++;
    end
    chk(int'(rspAdj) == 1, "R9 walk returns old leaf", int'(rspAdj), 1);
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    chk(wrReady == 1'b1, "R9 wrReady back when idle", int'(wrReady), 1);
    chk(reqReady == 1'b0, "R9 write priority blocks request", int'(reqReady), 0);
    @(negedge clk);
    wrEn = 1'b0;
    lookup(8'hF0, h, ad, d, c);
    chk(h == 1 && ad == 9, "R9 held write applied", ad, 9);

    // R6: child entry at the last level
    wrEntry(leafBase, 1, 0);
    lookup(8'h64, h, ad, d, c);
    chk(h == 0, "R6 child at last level misses", h, 0);
    chk(d == 3, "R6 depth", d, 3);

    // R3: reserved kind behaves as empty
    wrEntry(leafBase, 3, 5);
    lookup(8'h64, h, ad, d, c);
    chk(h == 0 && ad == 0, "R3 reserved kind misses", ad, 0);

    // R8: response held while consumer stalls
    reqValid = 1'b1;
    reqAddr = 8'h40;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R8 reqReady low after accept", int'(reqReady), 0);
    c = 0;
    while (!rspValid && c < 20) begin
      @(negedge clk);
      c++;
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rspValid == 1'b1 && int'(rspAdj) == 2, "R8 response held", int'(rspAdj), 2);
      chk(reqReady == 1'b0, "R8 no second request", int'(reqReady), 0);
    end
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    chk(rspValid == 1'b0, "R8 response released", int'(rspValid), 0);

    if (!doneFlag) begin
      doneFlag = 1;
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    wait (cycles > 100000);
    if (!doneFlag) begin
      doneFlag = 1;
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

endmodule